// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired sequencer that steers a multicycle processor datapath. Each instruction is broken into short steps (fetch, operand read, execute, memory access, result write), and the sequencer moves through a fixed set of 4-bit states. In each state it raises the enables and selects that the datapath needs for that step. The datapath holds the instruction register (IR), the operand registers A and B, the equality register E, the ALU result register S and the memory data register M.

The states are Moore states. Every output is set by the current state, apart from two refinements. First, in the branch state the PC select follows the equality input. Second, in the memory states the register-capture enables wait for the memory to stop reporting wait. The opcode is sampled only in the decode state, where it selects one of five execution paths of different lengths. The opcode is expected to come from the IR, so it is stable from decode onward.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the sequencer always starts at fetch.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While reset is asserted, and after reset is asserted at any time, the state output is 0000 (fetch). In fetch, memory read is 1.
- R2: Fetch (0000) moves to decode (0001) in the cycle after mem_wait_i is low. While mem_wait_i is high, the state stays in fetch. Decode raises a_en, b_en and e_en.
- R3: From decode the next state depends on the opcode: 000100 goes to 0011, 000000 to 0100, 001101 to 0110, 100011 to 1000 and 101011 to 1011.
- R4: Any other opcode in decode returns to fetch. On that path reg_wr, mem_wr and pc_en are never raised.
- R5: Register-register path: 0100 (s_en, alu_fn=11, which means use the function field, alu_imm=0), then 0101 (reg_wr, pc_en, dst_rd=1), then 0000.
- R6: OR-immediate path: 0110 (s_en, alu_fn=01 for OR, alu_imm=1, ext_sign=0), then 0111 (reg_wr, pc_en, dst_rd=0), then 0000.
- R7: Load path: 1000 (s_en, alu_fn=00 for add, alu_imm=1, ext_sign=1), then 1001 (mem_rd, m_en), then 1010 (reg_wr, pc_en, wb_mem=1, dst_rd=0), then 0000.
- R8: Store path: 1011 (same controls as 1000), then 1100 (mem_wr, pc_en), then 0000.
- R9: Branch state 0011 raises pc_en, drives pc_br equal to eq_i, and goes to 0000.
- R10: With no memory wait, an instruction takes 3 cycles for branch, 4 for register-register, OR-immediate and store, and 5 for load. An unknown opcode takes 2 cycles.
- R11: In 0000, 1001 and 1100 the state holds while mem_wait_i is high. In those cycles the capturing enable of that state (ir_en, m_en, pc_en respectively) is 0. It becomes 1 in the cycle mem_wait_i is low.
- R12: pc_en is 1 for exactly one cycle per known instruction. reg_wr is 1 for exactly one cycle on the register-register, OR-immediate and load paths, and never on the others. reg_wr and mem_wr are never 1 together.
- R13: Every control output not named for a state in R1 to R11 is 0 in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised |
| opcode_i | input | 6 | Opcode field from the instruction register |
| eq_i | input | 1 | Operand equality flag from the datapath |
| mem_wait_i | input | 1 | Memory not ready |
| state_o | output | 4 | Current sequencer state |
| ir_en_o | output | 1 | Instruction register load |
| a_en_o | output | 1 | Operand A load |
| b_en_o | output | 1 | Operand B load |
| e_en_o | output | 1 | Equality register load |
| s_en_o | output | 1 | ALU result register load |
| m_en_o | output | 1 | Memory data register load |
| pc_en_o | output | 1 | PC load |
| pc_br_o | output | 1 | PC select: 1 takes the branch target, 0 the next sequential address |
| alu_fn_o | output | 2 | ALU operation: 00 add, 01 OR, 11 use function field |
| alu_imm_o | output | 1 | ALU second operand from the extended immediate |
| ext_sign_o | output | 1 | Immediate extension: 1 sign, 0 zero |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| reg_wr_o | output | 1 | Register file write |
| wb_mem_o | output | 1 | Write-back data from M instead of S |
| dst_rd_o | output | 1 | Write destination rd (1) or rt (0) |

## Verification
The hardest case to reach is a stall inside the load or store memory state. The memory wait must be raised only after the sequencer has already passed decode on the right opcode, and the capture or PC enable must stay low for every stalled cycle. The bench drives mem_wait_i per state as it walks the expected state sequence. It holds the wait for a chosen number of cycles in each memory state, and it does this for all 64 opcodes under both equality values. An asynchronous reset raised in the middle of a load stall checks that the sequencer returns to fetch.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int OP_W = 6;
  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH    = 4'b0000,
    ST_DECODE   = 4'b0001,
    ST_BRANCH   = 4'b0011,
    ST_R_EXEC   = 4'b0100,
    ST_R_WB     = 4'b0101,
    ST_ORI_EXEC = 4'b0110,
    ST_ORI_WB   = 4'b0111,
    ST_LW_ADDR  = 4'b1000,
    ST_LW_MEM   = 4'b1001,
    ST_LW_WB    = 4'b1010,
    ST_SW_ADDR  = 4'b1011,
    ST_SW_MEM   = 4'b1100
  } mc_state_e;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_ORI   = 6'b001101;
  localparam logic [OP_W-1:0] OP_LW    = 6'b100011;
  localparam logic [OP_W-1:0] OP_SW    = 6'b101011;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'b00,
    ALU_OR    = 2'b01,
    ALU_FUNCT = 2'b11
  } alu_fn_e;

  typedef struct packed {
    logic    ir_en;
    logic    a_en;
    logic    b_en;
    logic    e_en;
    logic    s_en;
    logic    m_en;
    logic    pc_en;
    logic    pc_br;
    alu_fn_e alu_fn;
    logic    alu_imm;
    logic    ext_sign;
    logic    mem_rd;
    logic    mem_wr;
    logic    reg_wr;
    logic    wb_mem;
    logic    dst_rd;
  } mc_ctrl_t;

endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  mc_state_e       state,
  input  logic [OP_W-1:0] opcode,
  input  logic            mem_wait,
  output mc_state_e       state_nxt
);
  always_comb begin
    state_nxt = ST_FETCH;
    unique case (state)
      ST_FETCH:    state_nxt = mem_wait ? ST_FETCH : ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_BEQ:   state_nxt = ST_BRANCH;
          OP_RTYPE: state_nxt = ST_R_EXEC;
          OP_ORI:   state_nxt = ST_ORI_EXEC;
          OP_LW:    state_nxt = ST_LW_ADDR;
          OP_SW:    state_nxt = ST_SW_ADDR;
          default:  state_nxt = ST_FETCH;
        endcase
      end
      ST_BRANCH:   state_nxt = ST_FETCH;
      ST_R_EXEC:   state_nxt = ST_R_WB;
      ST_R_WB:     state_nxt = ST_FETCH;
      ST_ORI_EXEC: state_nxt = ST_ORI_WB;
      ST_ORI_WB:   state_nxt = ST_FETCH;
      ST_LW_ADDR:  state_nxt = ST_LW_MEM;
      ST_LW_MEM:   state_nxt = mem_wait ? ST_LW_MEM : ST_LW_WB;
      ST_LW_WB:    state_nxt = ST_FETCH;
      ST_SW_ADDR:  state_nxt = ST_SW_MEM;
      ST_SW_MEM:   state_nxt = mem_wait ? ST_SW_MEM : ST_FETCH;
      default:     state_nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg
  import mc_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  mc_state_e state_nxt,
  output mc_state_e state_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_nxt;
  end
endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
  import mc_ctrl_pkg::*;
(
  input  mc_state_e state,
  input  logic      mem_wait,
  input  logic      eq,
  output mc_ctrl_t  ctl
);
  logic mem_done;
  assign mem_done = ~mem_wait;

  always_comb begin
    ctl = '0;
    case (state)
      ST_FETCH: begin
        ctl.mem_rd = 1'b1;
        ctl.ir_en  = mem_done;
      end
      ST_DECODE: begin
        ctl.a_en = 1'b1;
        ctl.b_en = 1'b1;
        ctl.e_en = 1'b1;
      end
      ST_BRANCH: begin
        ctl.pc_en = 1'b1;
        ctl.pc_br = eq;
      end
      ST_R_EXEC: begin
        ctl.s_en   = 1'b1;
        ctl.alu_fn = ALU_FUNCT;
      end
      ST_R_WB: begin
        ctl.reg_wr = 1'b1;
        ctl.pc_en  = 1'b1;
        ctl.dst_rd = 1'b1;
      end
      ST_ORI_EXEC: begin
        ctl.s_en    = 1'b1;
        ctl.alu_fn  = ALU_OR;
        ctl.alu_imm = 1'b1;
      end
      ST_ORI_WB: begin
        ctl.reg_wr = 1'b1;
        ctl.pc_en  = 1'b1;
      end
      ST_LW_ADDR, ST_SW_ADDR: begin
        ctl.s_en     = 1'b1;
        ctl.alu_fn   = ALU_ADD;
        ctl.alu_imm  = 1'b1;
        ctl.ext_sign = 1'b1;
      end
      ST_LW_MEM: begin
        ctl.mem_rd = 1'b1;
        ctl.m_en   = mem_done;
      end
      ST_LW_WB: begin
        ctl.reg_wr = 1'b1;
        ctl.pc_en  = 1'b1;
        ctl.wb_mem = 1'b1;
      end
      ST_SW_MEM: begin
        ctl.mem_wr = 1'b1;
        ctl.pc_en  = mem_done;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode_i,
  input  logic            eq_i,
  input  logic            mem_wait_i,
  output logic [ST_W-1:0] state_o,
  output logic            ir_en_o,
  output logic            a_en_o,
  output logic            b_en_o,
  output logic            e_en_o,
  output logic            s_en_o,
  output logic            m_en_o,
  output logic            pc_en_o,
  output logic            pc_br_o,
  output logic [1:0]      alu_fn_o,
  output logic            alu_imm_o,
  output logic            ext_sign_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            reg_wr_o,
  output logic            wb_mem_o,
  output logic            dst_rd_o
);
  logic      rst_n_core;
  mc_state_e state_q;
  mc_state_e state_nxt;
  mc_ctrl_t  ctl;

  mc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_core)
  );

  mc_next_state u_next (
    .state     (state_q),
    .opcode    (opcode_i),
    .mem_wait  (mem_wait_i),
    .state_nxt (state_nxt)
  );

  mc_state_reg u_sreg (
    .clk       (clk),
    .rst_n     (rst_n_core),
    .state_nxt (state_nxt),
    .state_q   (state_q)
  );

  mc_out_decode u_dec (
    .state    (state_q),
    .mem_wait (mem_wait_i),
    .eq       (eq_i),
    .ctl      (ctl)
  );

  assign state_o    = state_q;
  assign ir_en_o    = ctl.ir_en;
  assign a_en_o     = ctl.a_en;
  assign b_en_o     = ctl.b_en;
  assign e_en_o     = ctl.e_en;
  assign s_en_o     = ctl.s_en;
  assign m_en_o     = ctl.m_en;
  assign pc_en_o    = ctl.pc_en;
  assign pc_br_o    = ctl.pc_br;
  assign alu_fn_o   = ctl.alu_fn;
  assign alu_imm_o  = ctl.alu_imm;
  assign ext_sign_o = ctl.ext_sign;
  assign mem_rd_o   = ctl.mem_rd;
  assign mem_wr_o   = ctl.mem_wr;
  assign reg_wr_o   = ctl.reg_wr;
  assign wb_mem_o   = ctl.wb_mem;
  assign dst_rd_o   = ctl.dst_rd;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] opcode_i,
  input logic       mem_wait_i,
  input logic [3:0] state_o,
  input logic       ir_en_o,
  input logic       pc_en_o,
  input logic       mem_wr_o,
  input logic       reg_wr_o
);
  logic op_known;
  assign op_known = (opcode_i == 6'b000000) || (opcode_i == 6'b000100) ||
                    (opcode_i == 6'b001101) || (opcode_i == 6'b100011) ||
                    (opcode_i == 6'b101011);

  p_fetch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'b0000 && mem_wait_i) |=> (state_o == 4'b0000));

  p_dispatch_lw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'b0001 && opcode_i == 6'b100011) |=> (state_o == 4'b1000));

  p_unknown_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'b0001 && !op_known) |=> (state_o == 4'b0000));

  p_lw_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'b1001 && !mem_wait_i) |=> (state_o == 4'b1010));

  p_store_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'b1100 && mem_wait_i) |-> !pc_en_o);

  p_fetch_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'b0000 && mem_wait_i) |-> !ir_en_o);

  p_one_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && mem_wr_o));

  p_wb_advances_pc_r12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> pc_en_o);
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .opcode_i   (opcode_i),
  .mem_wait_i (mem_wait_i),
  .state_o    (state_o),
  .ir_en_o    (ir_en_o),
  .pc_en_o    (pc_en_o),
  .mem_wr_o   (mem_wr_o),
  .reg_wr_o   (reg_wr_o)
);

// File: tb/mc_ctrl_fsm_test.sv
module mc_ctrl_fsm_test;
  localparam logic [3:0] S_F  = 4'b0000, S_D  = 4'b0001, S_BR = 4'b0011,
                         S_RX = 4'b0100, S_RW = 4'b0101, S_OX = 4'b0110,
                         S_OW = 4'b0111, S_LA = 4'b1000, S_LM = 4'b1001,
                         S_LW = 4'b1010, S_SA = 4'b1011, S_SM = 4'b1100;

  logic clk = 1'b0;
  logic rst_n;
  logic [5:0] opcode;
  logic eq, mem_wait;
  logic [3:0] state;
  logic ir_en, a_en, b_en, e_en, s_en, m_en, pc_en, pc_br;
  logic [1:0] alu_fn;
  logic alu_imm, ext_sign, mem_rd, mem_wr, reg_wr, wb_mem, dst_rd;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mc_ctrl_fsm uut (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .eq_i(eq), .mem_wait_i(mem_wait),
    .state_o(state), .ir_en_o(ir_en), .a_en_o(a_en), .b_en_o(b_en), .e_en_o(e_en),
    .s_en_o(s_en), .m_en_o(m_en), .pc_en_o(pc_en), .pc_br_o(pc_br),
    .alu_fn_o(alu_fn), .alu_imm_o(alu_imm), .ext_sign_o(ext_sign),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .reg_wr_o(reg_wr), .wb_mem_o(wb_mem),
    .dst_rd_o(dst_rd)
  );

  wire [16:0] ctl_vec = {ir_en, a_en, b_en, e_en, s_en, m_en, pc_en, pc_br,
                         alu_fn, alu_imm, ext_sign, mem_rd, mem_wr, reg_wr,
                         wb_mem, dst_rd};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] s);
    case (s)
      S_F:        return "R2";
      S_D:        return "R3";
      S_BR:       return "R9";
      S_RX, S_RW: return "R5";
      S_OX, S_OW: return "R6";
      S_LA, S_LM, S_LW: return "R7";
      default:    return "R8";
    endcase
  endfunction

  function automatic bit is_mem(input logic [3:0] s);
    return (s == S_F) || (s == S_LM) || (s == S_SM);
  endfunction

  // Expected controls from R1..R13 (all unnamed outputs zero per R13)
  function automatic logic [16:0] exp_ctl(input logic [3:0] s, input bit w, input bit e);
    logic ir_e, a_e, b_e, e_e, s_e, m_e, pc_e, br, imm, sx, rd, wr, rw, wbm, dr;
    logic [1:0] fn;
    {ir_e, a_e, b_e, e_e, s_e, m_e, pc_e, br, imm, sx, rd, wr, rw, wbm, dr} = '0;
    fn = 2'b00;
    case (s)
      S_F:  begin rd = 1; ir_e = !w; end
      S_D:  begin a_e = 1; b_e = 1; e_e = 1; end
      S_BR: begin pc_e = 1; br = e; end
      S_RX: begin s_e = 1; fn = 2'b11; end
      S_RW: begin rw = 1; pc_e = 1; dr = 1; end
      S_OX: begin s_e = 1; fn = 2'b01; imm = 1; end
      S_OW: begin rw = 1; pc_e = 1; end
      S_LA, S_SA: begin s_e = 1; imm = 1; sx = 1; end
      S_LM: begin rd = 1; m_e = !w; end
      S_LW: begin rw = 1; pc_e = 1; wbm = 1; end
      S_SM: begin wr = 1; pc_e = !w; end
      default: ;
    endcase
    return {ir_e, a_e, b_e, e_e, s_e, m_e, pc_e, br, fn, imm, sx, rd, wr, rw, wbm, dr};
  endfunction

  function automatic int base_cycles(input logic [5:0] op);
    case (op)
      6'b000100: return 3;
      6'b000000, 6'b001101, 6'b101011: return 4;
      6'b100011: return 5;
      default:   return 2;
    endcase
  endfunction

  task automatic run_instr(input logic [5:0] op, input bit e, input int nw);
    logic [3:0] seq [0:4];
    int len, pc_cnt, rw_cnt, mw_cnt, nmem;
    string tag;
    seq[0] = S_F; seq[1] = S_D; len = 2;
    case (op)
      6'b000100: begin seq[2] = S_BR; len = 3; end
      6'b000000: begin seq[2] = S_RX; seq[3] = S_RW; len = 4; end
      6'b001101: begin seq[2] = S_OX; seq[3] = S_OW; len = 4; end
      6'b100011: begin seq[2] = S_LA; seq[3] = S_LM; seq[4] = S_LW; len = 5; end
      6'b101011: begin seq[2] = S_SA; seq[3] = S_SM; len = 4; end
      default: ;
    endcase
    pc_cnt = 0; rw_cnt = 0; mw_cnt = 0; nmem = 0;
    for (int i = 0; i < len; i++) begin
      int reps;
      reps = is_mem(seq[i]) ? nw + 1 : 1;
      if (is_mem(seq[i])) nmem++;
      for (int r = 0; r < reps; r++) begin
        bit w;
        @(negedge clk);
        w = is_mem(seq[i]) && (r < nw);
        opcode = op; eq = e; mem_wait = w;
        #1;
        tag = (w && i > 0) ? "R11" : req_of(seq[i]);
        chk(state == seq[i], {tag, " state"}, state, seq[i]);
        chk(ctl_vec == exp_ctl(seq[i], w, e), {tag, " controls/R13"}, ctl_vec,
            exp_ctl(seq[i], w, e));
        pc_cnt += pc_en; rw_cnt += reg_wr; mw_cnt += mem_wr;
      end
    end
    // R10: path length without waits
    chk(len == base_cycles(op), "R10 cycle count", len, base_cycles(op));
    if (base_cycles(op) == 2) begin
      chk(pc_cnt == 0 && rw_cnt == 0 && mw_cnt == 0, "R4 no write", pc_cnt + rw_cnt + mw_cnt, 0);
    end else begin
      int exp_rw;
      exp_rw = (op == 6'b000000 || op == 6'b001101 || op == 6'b100011) ? 1 : 0;
      chk(pc_cnt == 1, "R12 pc_en once", pc_cnt, 1);
      chk(rw_cnt == exp_rw, "R12 reg_wr count", rw_cnt, exp_rw);
      chk(mw_cnt == ((op == 6'b101011) ? nw + 1 : 0), "R8 mem_wr cycles", mw_cnt,
          (op == 6'b101011) ? nw + 1 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; opcode = 6'b100011; eq = 1'b0; mem_wait = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(state == S_F, "R1 reset state", state, S_F);
    chk(mem_rd == 1'b1, "R1 fetch read", mem_rd, 1);
    @(negedge clk);
    mem_wait = 1'b1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(state == S_F, "R2 hold in fetch while waiting", state, S_F);
    chk(ir_en == 1'b0, "R11 ir_en low while waiting", ir_en, 0);

    for (int op = 0; op < 64; op++)
      for (int e = 0; e < 2; e++)
        for (int k = 0; k < 2; k++)
          run_instr(op[5:0], e[0], k * 2);

    // R1: asynchronous reset in the middle of a load memory stall
    @(negedge clk); opcode = 6'b100011; mem_wait = 1'b0; #1;
    chk(state == S_F, "R1 fetch before load", state, S_F);
    repeat (2) @(negedge clk);
    mem_wait = 1'b1;
    @(negedge clk); #1;
    chk(state == S_LM, "R7 reached load memory state", state, S_LM);
    rst_n = 1'b0;
    #1;
    chk(state == S_F, "R1 async reset to fetch", state, S_F);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(state == S_F, "R1 fetch after reset release", state, S_F);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule